// File: doc/BRIEF.md
# Shared Luma/Chroma Extended Vertical Interpolator

This block computes the second vertical interpolation pass that some frame/field layer pairings need when an enhancement-layer intra block is predicted from an upsampled reference layer. Each valid cycle it takes four vertically consecutive results from the first interpolation pass, `smp_a` (top) to `smp_d` (bottom). It returns one unnormalised sample. A mode input selects between a four-tap luma kernel and a two-tap chroma average.

The luma kernel weights the inner two samples by 19, weights the outer two by -3 and adds a rounding constant of 16. The block evaluates it as sixteen times the inner pair term minus three times the difference between the outer and inner pair terms. The inner pair term, `smp_b + smp_c + 1`, is the chroma result, so both modes use one adder tree with no multipliers. The output shift and clipping are left to the consumer. A prediction engine places several copies of this block side by side.

Top module: `ext_vinterp`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_sum` is 0.
- R2: With `chroma_sel` = 0, a sample accepted on a clock edge gives `out_sum` = 19*(b+c) - 3*(a+d) + 16 after that edge, exactly and in signed arithmetic.
- R3: With `chroma_sel` = 1, the result is b + c + 1. The values on `smp_a` and `smp_d` have no effect on it.
- R4: `out_valid` is high in the cycle after an edge where `in_valid` was high, and low in the cycle after an edge where it was low.
- R5: When `in_valid` is low, `out_sum` keeps its previous value.
- R6: Every result is exact for all 16-bit signed inputs, including both extreme values, and never wraps in the 22-bit output.
- R7: `chroma_sel` is sampled with each input. Back-to-back samples in different modes each produce their own mode's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample set is valid |
| chroma_sel | input | 1 | 1 selects chroma (2-tap), 0 selects luma (4-tap) |
| smp_a | input | 16 | Topmost first-pass value, signed (luma only) |
| smp_b | input | 16 | Second first-pass value, signed |
| smp_c | input | 16 | Third first-pass value, signed |
| smp_d | input | 16 | Bottom first-pass value, signed (luma only) |
| out_valid | output | 1 | Result valid |
| out_sum | output | 22 | Signed unnormalised result |

## Verification
The bench drives all four inputs to +32767, then all to -32768, then mixes with the outer samples at one extreme and the inner samples at the other. A design with an adder or shift that is too narrow, or that drops sign extension, returns a wrapped value or one with the wrong sign. Chroma samples carry large unrelated values on the outer ports, so a mode decode that leaks those values changes the output. Consecutive cycles alternate between modes, which exposes a mode select that is registered one cycle late. Idle gaps show whether the output register is loaded while `in_valid` is low. Random vectors are compared against the direct-form equation.

// File: rtl/ext_vinterp.sv
module ext_vinterp #(
  parameter int IW = 16,
  parameter int OW = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 chroma_sel,
  input  logic signed [IW-1:0] smp_a,
  input  logic signed [IW-1:0] smp_b,
  input  logic signed [IW-1:0] smp_c,
  input  logic signed [IW-1:0] smp_d,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_sum
);
  localparam int PW = IW + 2;
  localparam int DW = IW + 3;

  logic signed [PW-1:0] pair_bc, pair_ad;
  logic signed [DW-1:0] pair_diff;
  logic signed [OW-1:0] bc_x16, diff_x3, luma_val, next_val;

  assign pair_bc   = PW'(smp_b) + PW'(smp_c) + PW'(1);
  assign pair_ad   = PW'(smp_a) + PW'(smp_d) + PW'(1);
  assign pair_diff = DW'(pair_ad) - DW'(pair_bc);
  assign bc_x16    = OW'(pair_bc) <<< 4;
  assign diff_x3   = (OW'(pair_diff) <<< 1) + OW'(pair_diff);
  assign luma_val  = bc_x16 - diff_x3;
  assign next_val  = chroma_sel ? OW'(pair_bc) : luma_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sum <= next_val;
    end
  end

  logic signed [OW-1:0] ax, bx, cx, dx;
  assign ax = OW'(smp_a);
  assign bx = OW'(smp_b);
  assign cx = OW'(smp_c);
  assign dx = OW'(smp_d);

  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_sum == '0));
  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));
  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sum));
  // R2
  luma_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !chroma_sel) |=>
      out_sum == OW'(19) * ($past(bx) + $past(cx)) - OW'(3) * ($past(ax) + $past(dx)) + OW'(16));
  // R3
  chroma_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && chroma_sel) |=> out_sum == $past(bx) + $past(cx) + OW'(1));
endmodule

// File: tb/ext_vinterp_tb_top.sv
module ext_vinterp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic chroma_sel = 1'b0;
  logic signed [15:0] a = '0, b = '0, c = '0, d = '0;
  logic out_valid;
  logic signed [21:0] out_sum;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_vinterp dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .chroma_sel(chroma_sel),
    .smp_a(a), .smp_b(b), .smp_c(c), .smp_d(d),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  function automatic logic signed [21:0] ref_val(bit m, int va, int vb, int vc, int vd);
    int r;
    if (m) r = vb + vc + 1;
    else   r = 19 * vb + 19 * vc - 3 * va - 3 * vd + 16;
    return 22'(r);
  endfunction

  task automatic chk(string req, logic signed [21:0] act, logic signed [21:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp_v);
    end
  endtask

  // drive one sample at a negedge, check result at next negedge
  task automatic step(string req, bit m, int va, int vb, int vc, int vd);
    in_valid = 1'b1; chroma_sel = m;
    a = 16'(va); b = 16'(vb); c = 16'(vc); d = 16'(vd);
    @(negedge clk);
    chk_bit({req, " valid"}, out_valid, 1'b1);
    chk(req, out_sum, ref_val(m, va, vb, vc, vd));
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk_bit("R1 valid", out_valid, 1'b0);
    chk("R1 sum", out_sum, 22'sd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_luma();
    step("R2 small", 0, 1, 2, 3, 4);
    step("R2 negative", 0, -10, -20, 30, -40);
    step("R2 zero", 0, 0, 0, 0, 0);
  endtask

  task automatic test_chroma();
    step("R3 basic", 1, 32767, 100, 200, -32768);
    step("R3 outer swap", 1, -32768, 100, 200, 32767);
    step("R3 negative", 1, 1234, -500, -7, -999);
  endtask

  task automatic test_extremes();
    step("R6 all max", 0, 32767, 32767, 32767, 32767);
    step("R6 all min", 0, -32768, -32768, -32768, -32768);
    step("R6 inner max", 0, -32768, 32767, 32767, -32768);
    step("R6 inner min", 0, 32767, -32768, -32768, 32767);
    step("R6 chroma max", 1, 0, 32767, 32767, 0);
    step("R6 chroma min", 1, 0, -32768, -32768, 0);
  endtask

  task automatic test_idle_hold();
    logic signed [21:0] held;
    step("R5 load", 0, 5, 6, 7, 8);
    held = out_sum;
    in_valid = 1'b0;
    a = 16'sd999; b = -16'sd999; c = 16'sd77; d = 16'sd1;
    @(negedge clk);
    chk_bit("R4 idle valid", out_valid, 1'b0);
    chk("R5 hold", out_sum, held);
    @(negedge clk);
    chk("R5 hold2", out_sum, held);
  endtask

  task automatic test_mode_switch();
    for (int i = 0; i < 8; i++)
      step("R7 alternate", i[0], 300 * i - 900, 11 * i, -17 * i + 5, 1000 - i);
  endtask

  task automatic test_random();
    for (int i = 0; i < 200; i++) begin
      int ra, rb, rc, rd;
      ra = int'($signed(16'($urandom)));
      rb = int'($signed(16'($urandom)));
      rc = int'($signed(16'($urandom)));
      rd = int'($signed(16'($urandom)));
      step("R2/R3 random", bit'($urandom & 1), ra, rb, rc, rd);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk_bit("R4 drop", out_valid, 1'b0);
  endtask

  initial begin
    test_reset();
    test_luma();
    test_chroma();
    test_extremes();
    test_idle_hold();
    test_mode_switch();
    test_random();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule